// File: doc/BRIEF.md
# Raster Timing Generator with Frame Event Counters

This block produces horizontal and vertical raster timing for one display pipe. It runs from the pixel clock and is programmed through a set of timing inputs: horizontal total, blank start, sync start and end, and the vertical equivalents, plus a 2-bit frame-start delay. It drives level strobes for blank and sync, single-cycle event pulses for start of vertical blank, start of vertical sync and frame start, and three counters for software to read back: a scanline counter, a frame counter and a pixel counter.

The timing inputs are a shadow copy. They are captured into the working set once, on the first clock after reset, and after that only at the start-of-vblank event. Software can therefore rewrite them at any time during a frame and know that the change takes effect cleanly at the next vertical blank. Vertical events line up with the leading edge of horizontal sync, not with the line start. Frame start is the exception: it lines up with horizontal blank start, a programmable number of lines later.

Top module: `raster_timing_gen`

## Requirements
- R1: The start-of-vblank pulse fires at the first cycle of horizontal sync (horizontal count equal to sync start) on line vblank_start-1. The start-of-vsync pulse fires at the same horizontal point on line vsync_start-1. In both cases hsync_o is high in the pulse cycle and was low in the cycle before.
- R2: In the cycle after the start-of-vblank pulse, the frame counter has grown by one and the working timing set holds the shadow inputs sampled in the pulse cycle. The frame counter changes at no other time.
- R3: frame_start_o pulses at horizontal count hblank_start on line vblank_start+fs_delay_i, where fs_delay_i is 0 to 3. That is 1 to 4 lines after the start of vblank. vtotal must exceed vblank_start+fs_delay_i.
- R4: The scanline counter loads the current line number at each horizontal sync start. It therefore reads vtotal-1 on the first active line, and vblank_start-1 in the cycle after the start-of-vblank pulse.
- R5: The frame counter is FRAME_W bits wide (default 24) and wraps to zero after 2^FRAME_W-1.
- R6: The pixel counter reads 0 at the first visible pixel (line 0, count 0) and v*htotal+h elsewhere. At the start of line vblank_start it therefore reads vblank_start*htotal.
- R7: vblank_o is high from the start-of-vblank pulse to the end of the last line of the frame. vsync_o is high from the start-of-vsync pulse up to, but not including, the sync start of line vsync_end-1.
- R8: A change to the shadow inputs after a start-of-vblank pulse has no effect on the current frame. The frame length and the event positions follow the values sampled at the pulse.
- R9: While reset is asserted, all strobes, pulses and counters are zero. Each event pulse lasts exactly one cycle.
- R10: hsync_o is high for horizontal counts in [hsync_start, hsync_end). hblank_o is high for counts in [hblank_start, htotal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| htotal_i | input | TIME_W | Shadow: pixels per line |
| hblank_start_i | input | TIME_W | Shadow: first horizontal blank pixel |
| hsync_start_i | input | TIME_W | Shadow: first horizontal sync pixel |
| hsync_end_i | input | TIME_W | Shadow: first pixel after horizontal sync |
| vtotal_i | input | TIME_W | Shadow: lines per frame |
| vblank_start_i | input | TIME_W | Shadow: first vertical blank line |
| vsync_start_i | input | TIME_W | Shadow: first vertical sync line |
| vsync_end_i | input | TIME_W | Shadow: first line after vertical sync |
| fs_delay_i | input | 2 | Shadow: extra frame-start lines (0..3) |
| hblank_o | output | 1 | Horizontal blank level |
| hsync_o | output | 1 | Horizontal sync level |
| vblank_o | output | 1 | Vertical blank level |
| vsync_o | output | 1 | Vertical sync level |
| vblank_evt_o | output | 1 | Start-of-vblank pulse |
| vsync_evt_o | output | 1 | Start-of-vsync pulse |
| frame_start_o | output | 1 | Delayed frame-start pulse |
| scanline_o | output | TIME_W | Scanline readback |
| frame_cnt_o | output | FRAME_W | Frame counter |
| pixel_cnt_o | output | 2*TIME_W | Pixel counter |

## Verification
The assertions assume a sane timing set: hblank_start <= hsync_start < hsync_end < htotal, vblank_start >= 3, vblank_start < vsync_start < vsync_end <= vtotal, and vtotal greater than vblank_start plus the frame-start delay. Under these limits the two vertical pulses can never coincide, and sync always falls inside the line. The stimulus keeps the horizontal set and vblank_start fixed. Between frames it varies vtotal, vsync position and delay within these limits. The deliberately wrong shadow values it writes during vertical blank also stay legal, so an ignored write can be told apart from a malformed one.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned TIME_W = 12;
  localparam int unsigned PIX_W  = 2 * TIME_W;

  typedef logic [TIME_W-1:0] tcount_t;

  typedef struct packed {
    tcount_t    htotal;
    tcount_t    hblank_start;
    tcount_t    hsync_start;
    tcount_t    hsync_end;
    tcount_t    vtotal;
    tcount_t    vblank_start;
    tcount_t    vsync_start;
    tcount_t    vsync_end;
    logic [1:0] fs_delay;
  } timing_t;
endpackage

// File: rtl/raster_shadow.sv
module raster_shadow
  import raster_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  timing_t shadow_i,
  output timing_t active_o
);
  timing_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= shadow_i;
  end

  assign active_o = act_q;
endmodule

// File: rtl/raster_hcount.sv
module raster_hcount
  import raster_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  tcount_t htotal_i,
  input  tcount_t hblank_start_i,
  input  tcount_t hsync_start_i,
  input  tcount_t hsync_end_i,
  output logic    line_end_o,
  output logic    hsync_rise_o,
  output logic    hblank_rise_o,
  output logic    hsync_o,
  output logic    hblank_o
);
  tcount_t h_q;

  assign line_end_o = run_i && (h_q == htotal_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         h_q <= '0;
    else if (!run_i)     h_q <= '0;
    else if (line_end_o) h_q <= '0;
    else                 h_q <= h_q + 1'b1;
  end

  assign hsync_rise_o  = run_i && (h_q == hsync_start_i);
  assign hblank_rise_o = run_i && (h_q == hblank_start_i);
  assign hsync_o       = run_i && (h_q >= hsync_start_i) && (h_q < hsync_end_i);
  assign hblank_o      = run_i && (h_q >= hblank_start_i);
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       line_end_i,
  input  logic       hsync_rise_i,
  input  logic       hblank_rise_i,
  input  tcount_t    vtotal_i,
  input  tcount_t    vblank_start_i,
  input  tcount_t    vsync_start_i,
  input  tcount_t    vsync_end_i,
  input  logic [1:0] fs_delay_i,
  output logic       frame_end_o,
  output logic       vblank_evt_o,
  output logic       vsync_evt_o,
  output logic       frame_start_o,
  output logic       vblank_o,
  output logic       vsync_o,
  output tcount_t    scanline_o
);
  tcount_t           v_q;
  tcount_t           scan_q;
  logic              vb_q, vs_q;
  logic              vs_end;
  logic [TIME_W:0]   fs_line;

  assign frame_end_o = line_end_i && (v_q == vtotal_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          v_q <= '0;
    else if (!run_i)      v_q <= '0;
    else if (frame_end_o) v_q <= '0;
    else if (line_end_i)  v_q <= v_q + 1'b1;
  end

  // vertical events sit on the leading edge of hsync of the preceding line
  assign vblank_evt_o = hsync_rise_i && (v_q == vblank_start_i - 1'b1);
  assign vsync_evt_o  = hsync_rise_i && (v_q == vsync_start_i - 1'b1);
  assign vs_end       = hsync_rise_i && (v_q == vsync_end_i - 1'b1);

  assign fs_line       = {1'b0, vblank_start_i} + fs_delay_i;
  assign frame_start_o = hblank_rise_i && ({1'b0, v_q} == fs_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q   <= 1'b0;
      vs_q   <= 1'b0;
      scan_q <= '0;
    end else begin
      if (vblank_evt_o)     vb_q <= 1'b1;
      else if (frame_end_o) vb_q <= 1'b0;
      if (vsync_evt_o)      vs_q <= 1'b1;
      else if (vs_end)      vs_q <= 1'b0;
      if (hsync_rise_i)     scan_q <= v_q;
    end
  end

  assign vblank_o   = vblank_evt_o || vb_q;
  assign vsync_o    = vsync_evt_o || (vs_q && !vs_end);
  assign scanline_o = scan_q;
endmodule

// File: rtl/raster_counters.sv
module raster_counters
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               frame_end_i,
  input  logic               vblank_evt_i,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic [PIX_W-1:0]   pixel_cnt_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [PIX_W-1:0]   pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           frame_q <= '0;
    else if (vblank_evt_i) frame_q <= frame_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pix_q <= '0;
    else if (!run_i)      pix_q <= '0;
    else if (frame_end_i) pix_q <= '0;
    else                  pix_q <= pix_q + 1'b1;
  end

  assign frame_cnt_o = frame_q;
  assign pixel_cnt_o = pix_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TIME_W-1:0]  htotal_i,
  input  logic [TIME_W-1:0]  hblank_start_i,
  input  logic [TIME_W-1:0]  hsync_start_i,
  input  logic [TIME_W-1:0]  hsync_end_i,
  input  logic [TIME_W-1:0]  vtotal_i,
  input  logic [TIME_W-1:0]  vblank_start_i,
  input  logic [TIME_W-1:0]  vsync_start_i,
  input  logic [TIME_W-1:0]  vsync_end_i,
  input  logic [1:0]         fs_delay_i,
  output logic               hblank_o,
  output logic               hsync_o,
  output logic               vblank_o,
  output logic               vsync_o,
  output logic               vblank_evt_o,
  output logic               vsync_evt_o,
  output logic               frame_start_o,
  output logic [TIME_W-1:0]  scanline_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic [PIX_W-1:0]   pixel_cnt_o
);
  timing_t shadow, act;
  logic    pending_q, run;
  logic    line_end, hsync_rise, hblank_rise, frame_end, vbl_evt;

  // first clock after reset primes the working set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b1;
    else         pending_q <= 1'b0;
  end
  assign run = !pending_q;

  assign shadow = '{htotal: htotal_i, hblank_start: hblank_start_i,
                    hsync_start: hsync_start_i, hsync_end: hsync_end_i,
                    vtotal: vtotal_i, vblank_start: vblank_start_i,
                    vsync_start: vsync_start_i, vsync_end: vsync_end_i,
                    fs_delay: fs_delay_i};

  raster_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pending_q || vbl_evt),
    .shadow_i (shadow),
    .active_o (act)
  );

  raster_hcount u_hcount (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (run),
    .htotal_i       (act.htotal),
    .hblank_start_i (act.hblank_start),
    .hsync_start_i  (act.hsync_start),
    .hsync_end_i    (act.hsync_end),
    .line_end_o     (line_end),
    .hsync_rise_o   (hsync_rise),
    .hblank_rise_o  (hblank_rise),
    .hsync_o        (hsync_o),
    .hblank_o       (hblank_o)
  );

  raster_vcount u_vcount (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (run),
    .line_end_i     (line_end),
    .hsync_rise_i   (hsync_rise),
    .hblank_rise_i  (hblank_rise),
    .vtotal_i       (act.vtotal),
    .vblank_start_i (act.vblank_start),
    .vsync_start_i  (act.vsync_start),
    .vsync_end_i    (act.vsync_end),
    .fs_delay_i     (act.fs_delay),
    .frame_end_o    (frame_end),
    .vblank_evt_o   (vbl_evt),
    .vsync_evt_o    (vsync_evt_o),
    .frame_start_o  (frame_start_o),
    .vblank_o       (vblank_o),
    .vsync_o        (vsync_o),
    .scanline_o     (scanline_o)
  );

  raster_counters #(.FRAME_W(FRAME_W)) u_counters (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .frame_end_i  (frame_end),
    .vblank_evt_i (vbl_evt),
    .frame_cnt_o  (frame_cnt_o),
    .pixel_cnt_o  (pixel_cnt_o)
  );

  assign vblank_evt_o = vbl_evt;
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hsync_o,
  input logic               vblank_o,
  input logic               vblank_evt_o,
  input logic               vsync_evt_o,
  input logic               frame_start_o,
  input logic [TIME_W-1:0]  scanline_o,
  input logic [FRAME_W-1:0] frame_cnt_o
);
  // R1
  vblank_evt_on_hsync_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_evt_o |-> hsync_o && !$past(hsync_o));
  // R1
  vsync_evt_on_hsync_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_evt_o |-> hsync_o && !$past(hsync_o));
  // R2
  frame_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_evt_o |=> frame_cnt_o == FRAME_W'($past(frame_cnt_o) + 1'b1));
  // R2
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_evt_o |=> $stable(frame_cnt_o));
  // R4
  scan_moves_at_hsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scanline_o) |-> $past(hsync_o));
  // R7
  vblank_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_evt_o |=> vblank_o);
  // R9
  evt_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vblank_evt_o, vsync_evt_o}));
  // R9
  vblank_evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_evt_o |=> !vblank_evt_o);
  // R9
  frame_start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hsync_o       (hsync_o),
  .vblank_o      (vblank_o),
  .vblank_evt_o  (vblank_evt_o),
  .vsync_evt_o   (vsync_evt_o),
  .frame_start_o (frame_start_o),
  .scanline_o    (scanline_o),
  .frame_cnt_o   (frame_cnt_o)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  import raster_pkg::*;

  localparam int FW  = 3;
  localparam int HT  = 20;
  localparam int HBS = 14;
  localparam int HSS = 16;
  localparam int HSE = 18;
  localparam int VBS = 6;
  localparam int NFR = 10;

  localparam int K_VBL = 0, K_FS = 1, K_VS = 2, K_SCAN = 3, K_FCNT = 4,
                 K_PIX = 5, K_VBLANK = 6, K_VSYNC = 7, K_HSYNC = 8, K_HBLANK = 9;

  typedef struct packed {
    int cyc;
    int kind;
    int val;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TIME_W-1:0] vt_s, vbs_s, vss_s, vse_s;
  logic [1:0] fsd_s;
  logic hblank, hsync, vblank, vsync, vbl_evt, vs_evt, fs_evt;
  logic [TIME_W-1:0] scan;
  logic [FW-1:0] fcnt;
  logic [PIX_W-1:0] pix;

  int edges = 0;
  int checks = 0;
  int errors = 0;
  item_t q[$];

  always #4 clk = ~clk;

  raster_timing_gen #(.FRAME_W(FW)) u_raster_timing_gen (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .htotal_i       (TIME_W'(HT)),
    .hblank_start_i (TIME_W'(HBS)),
    .hsync_start_i  (TIME_W'(HSS)),
    .hsync_end_i    (TIME_W'(HSE)),
    .vtotal_i       (vt_s),
    .vblank_start_i (vbs_s),
    .vsync_start_i  (vss_s),
    .vsync_end_i    (vse_s),
    .fs_delay_i     (fsd_s),
    .hblank_o       (hblank),
    .hsync_o        (hsync),
    .vblank_o       (vblank),
    .vsync_o        (vsync),
    .vblank_evt_o   (vbl_evt),
    .vsync_evt_o    (vs_evt),
    .frame_start_o  (fs_evt),
    .scanline_o     (scan),
    .frame_cnt_o    (fcnt),
    .pixel_cnt_o    (pix)
  );

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic int f_d(int k);   return k % 4; endfunction
  function automatic int f_vt(int k);  return 9 + ((k % 4) == 3 ? 1 : 0) + (k >= 7 ? 2 : 0); endfunction
  function automatic int f_vss(int k); return (k >= 7) ? 8 : 7; endfunction
  function automatic int f_vse(int k); return (k >= 7) ? 10 : 8; endfunction

  function automatic string req_of(int kind);
    case (kind)
      K_VBL, K_VS:       return "R1";
      K_FS:              return "R3";
      K_SCAN:            return "R4";
      K_FCNT:            return "R5";
      K_PIX:             return "R6";
      K_VBLANK, K_VSYNC: return "R7";
      default:           return "R10";
    endcase
  endfunction

  task automatic push(int c, int kind, int val);
    int i = 0;
    while (i < q.size() && q[i].cyc <= c) i++;
    q.insert(i, '{cyc: c, kind: kind, val: val});
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_shadow(int vt, int vss, int vse, int d);
    vt_s  = TIME_W'(vt);
    vbs_s = TIME_W'(VBS);
    vss_s = TIME_W'(vss);
    vse_s = TIME_W'(vse);
    fsd_s = 2'(d);
  endtask

  task automatic wait_pos(int target);
    while (edges - 1 != target) @(negedge clk);
  endtask

  // monitor: pop items due this cycle and compare
  always @(negedge clk) begin
    if (rst_n && edges >= 1) begin
      int p;
      logic [2:0] exp_m, obs_m;
      item_t it;
      int act;
      p = edges - 1;
      exp_m = '0;
      obs_m = {vs_evt, fs_evt, vbl_evt};
      while (q.size() > 0 && q[0].cyc <= p) begin
        it = q.pop_front();
        if (it.kind <= K_VS) exp_m[it.kind] = 1'b1;
        else begin
          case (it.kind)
            K_SCAN:   act = int'(scan);
            K_FCNT:   act = int'(fcnt);
            K_PIX:    act = int'(pix);
            K_VBLANK: act = int'(vblank);
            K_VSYNC:  act = int'(vsync);
            K_HSYNC:  act = int'(hsync);
            default:  act = int'(hblank);
          endcase
          check(act == it.val && it.cyc == p, req_of(it.kind), $sformatf("kind %0d at %0d", it.kind, p), act, it.val);
        end
      end
      if (exp_m != 3'b000 || obs_m != 3'b000)
        check(exp_m == obs_m, "R1/R3 R9", $sformatf("event mask at %0d", p), int'(obs_m), int'(exp_m));
    end
  end

  initial begin
    #(8 * 60000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    s = 0;
    set_shadow(f_vt(0), f_vss(0), f_vse(0), f_d(0));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(fcnt == '0 && scan == '0 && pix == '0, "R9", "reset counters", int'(pix), 0);
    check({vbl_evt, vs_evt, fs_evt, hsync, hblank, vblank, vsync} == '0, "R9", "reset strobes",
          int'({vbl_evt, vs_evt, fs_evt, hsync, hblank, vblank, vsync}), 0);
    rst_n = 1'b1;
    for (int k = 0; k < NFR; k++) begin
      int evt, vt, vss, vse, d, ns, vs_at, ve_at;
      wait_pos(s + 2);
      vt = f_vt(k); vss = f_vss(k); vse = f_vse(k); d = f_d(k);
      set_shadow(vt, vss, vse, d);
      evt   = s + (VBS - 1) * HT + HSS;
      vs_at = s + (vss - 1) * HT + HSS;
      ve_at = s + (vse - 1) * HT + HSS;
      ns    = s + vt * HT;
      // R1 event on hsync edge
      push(evt, K_VBL, 1);
      push(evt - 1, K_HSYNC, 0);
      push(evt, K_HSYNC, 1);
      // R4 scanline before and after vblank event
      push(evt, K_SCAN, VBS - 2);
      push(evt + 1, K_SCAN, VBS - 1);
      // R2 R5 frame counter step and wrap
      push(evt, K_FCNT, k % (1 << FW));
      push(evt + 1, K_FCNT, (k + 1) % (1 << FW));
      // R7 levels
      push(evt - 1, K_VBLANK, 0);
      push(evt, K_VBLANK, 1);
      push(vs_at, K_VS, 1);
      push(vs_at - 1, K_VSYNC, 0);
      push(vs_at, K_VSYNC, 1);
      push(ve_at - 1, K_VSYNC, 1);
      push(ve_at, K_VSYNC, 0);
      // R3 delayed frame start
      push(s + (VBS + d) * HT + HBS, K_FS, 1);
      // R6 pixel counter
      push(s + VBS * HT, K_PIX, VBS * HT);
      push(s + HT + 5, K_PIX, HT + 5);
      // R10 horizontal strobes
      push(s + HT + HBS - 1, K_HBLANK, 0);
      push(s + HT + HBS, K_HBLANK, 1);
      push(s + HT + HSE - 1, K_HSYNC, 1);
      push(s + HT + HSE, K_HSYNC, 0);
      // R8 frame length follows value latched at vblank, not later writes
      push(ns - 1, K_VBLANK, 1);
      push(ns, K_VBLANK, 0);
      push(ns, K_PIX, 0);
      push(ns, K_SCAN, vt - 1);
      wait_pos(evt + 2);
      set_shadow(15, 9, 11, 2);
      s = ns;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule